// File: doc/BRIEF.md
# Manchester Edge-Interval Bit Recovery

This block turns one oversampled data line carrying Manchester-coded RFID modulation back into a stream of bits. It has no sampling clock locked to the middle of each bit. Instead it counts clock cycles between successive transitions of the line and sorts each interval into a short class (half a bit) or a long class (a whole bit). The sort uses a threshold at three quarters of the nominal bit period. From the class of the interval that just ended, and the class of the one before it, the block decides whether the transition that closed the interval produces a bit.

The nominal bit period is the product of a build-time constant, cycles of the system clock per carrier cycle, and a run-time choice of 64, 32 or 16 carrier cycles per bit. A polarity input picks how a held line level maps to a bit value. The line passes through a two-stage synchroniser first. Each recovered bit leaves on a registered output with a one-cycle strobe.

Top module: `manchester_bit_recover`

## Requirements
- R1: The nominal bit period in clock cycles is SPC_CYCLES times the data rate. rate_sel_i chooses the data rate: code 0 gives 64, code 1 gives 32, code 2 gives 16, and code 3 also gives 64.
- R2: An interval is the number of clock cycles between two consecutive line transitions. It is long when it is strictly greater than the nominal bit period minus a quarter of it, and short otherwise.
- R3: A long interval always produces exactly one bit at the transition that ends it.
- R4: A short interval that follows a long interval produces one bit at its ending transition.
- R5: A short interval that follows a short interval produces a bit only when the previous short interval produced none. The first interval after initialisation counts as following a short interval that produced none. As a result, a run of half-bit intervals yields one bit per pair.
- R6: The bit value is the line level held during the interval that just ended, XORed with polarity_i. With polarity_i = 1 the level is inverted; with polarity_i = 0 it passes unchanged.
- R7: The first line transition after reset only starts interval timing and produces no bit.
- R8: The interval counter stops at its all-ones value instead of wrapping. A line that stays idle for longer than the counter range is therefore still classed as long.
- R9: bit_valid_o is high for one cycle per recovered bit. It rises on the third rising clock edge after the line change that closed the interval: two synchroniser stages, then the output register.
- R10: While rst_n is low, bit_valid_o and bit_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | 1 | Raw asynchronous data line |
| rate_sel_i | input | 2 | Carrier cycles per bit: 0→64, 1→32, 2→16, 3→64 |
| polarity_i | input | 1 | 1 inverts the held level into the bit, 0 passes it |
| bit_o | output | 1 | Recovered bit value, meaningful when bit_valid_o is high |
| bit_valid_o | output | 1 | One-cycle strobe for each recovered bit |

## Verification
The strobe for a bit is due exactly three rising edges after the bench changes the line to end an interval. The bench drives the line on falling edges and logs the cycle count of each change. When a change should produce a bit, the bench queues the bit value together with that cycle count plus three. On every falling edge the bench samples the outputs, and each strobe must match the head of the queue in both value and cycle. A strobe with nothing queued, or a queue left non-empty after the line goes quiet, counts as a failure.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

    typedef enum logic [1:0] {
        RATE_SEL_64  = 2'd0,
        RATE_SEL_32  = 2'd1,
        RATE_SEL_16  = 2'd2,
        RATE_SEL_64B = 2'd3
    } rate_sel_e;

    typedef struct packed {
        logic primed;     // first transition seen since reset
        logic prev_long;  // class of the previous interval
        logic prev_emit;  // previous interval produced a bit
        logic bit_val;
        logic valid;
    } dec_state_t;

endpackage

// File: rtl/mbr_edge_sync.sv
module mbr_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic edge_o,
    output logic level_prev_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = line_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign edge_o       = st_q.s2 ^ st_q.prev;
    assign level_prev_o = st_q.prev;
endmodule

// File: rtl/mbr_interval.sv
module mbr_interval #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    output logic [CNT_W-1:0] interval_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (edge_i)
            cnt_d = CNT_W'(1);
        else if (cnt_q != CNT_MAX)
            cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign interval_o = cnt_q;
endmodule

// File: rtl/mbr_decide.sv
module mbr_decide
    import mbr_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic             level_prev_i,
    input  logic             polarity_i,
    input  logic [CNT_W-1:0] interval_i,
    input  logic [CNT_W-1:0] thresh_i,
    output logic             bit_o,
    output logic             valid_o,
    output logic             primed_o
);
    dec_state_t st_d, st_q;
    logic       is_long;
    logic       emit;

    always_comb begin
        st_d    = st_q;
        st_d.valid = 1'b0;
        is_long = (interval_i > thresh_i);
        emit    = is_long | st_q.prev_long | ~st_q.prev_emit;
        if (edge_i) begin
            if (!st_q.primed) begin
                st_d.primed    = 1'b1;
                st_d.prev_long = 1'b0;
                st_d.prev_emit = 1'b0;
            end else begin
                st_d.valid     = emit;
                st_d.prev_long = is_long;
                st_d.prev_emit = emit;
                if (emit)
                    st_d.bit_val = level_prev_i ^ polarity_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_o    = st_q.bit_val;
    assign valid_o  = st_q.valid;
    assign primed_o = st_q.primed;
endmodule

// File: rtl/manchester_bit_recover.sv
module manchester_bit_recover
    import mbr_pkg::*;
#(
    parameter int SPC_CYCLES = 4,
    parameter int MAX_RATE   = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_i,
    input  logic [1:0] rate_sel_i,
    input  logic       polarity_i,
    output logic       bit_o,
    output logic       bit_valid_o
);
    localparam int MAX_PERIOD = SPC_CYCLES * MAX_RATE;
    localparam int CNT_W      = $clog2(4 * MAX_PERIOD);

    logic             edge_w;
    logic             level_prev_w;
    logic             primed_w;
    logic [CNT_W-1:0] interval_w;
    logic [CNT_W-1:0] period_w;
    logic [CNT_W-1:0] thresh_w;

    always_comb begin
        unique case (rate_sel_e'(rate_sel_i))
            RATE_SEL_32: period_w = CNT_W'(SPC_CYCLES * (MAX_RATE / 2));
            RATE_SEL_16: period_w = CNT_W'(SPC_CYCLES * (MAX_RATE / 4));
            default:     period_w = CNT_W'(MAX_PERIOD);
        endcase
        thresh_w = period_w - (period_w >> 2);
    end

    mbr_edge_sync u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_i       (line_i),
        .edge_o       (edge_w),
        .level_prev_o (level_prev_w)
    );

    mbr_interval #(.CNT_W(CNT_W)) u_interval (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_i     (edge_w),
        .interval_o (interval_w)
    );

    mbr_decide #(.CNT_W(CNT_W)) u_decide (
        .clk          (clk),
        .rst_n        (rst_n),
        .edge_i       (edge_w),
        .level_prev_i (level_prev_w),
        .polarity_i   (polarity_i),
        .interval_i   (interval_w),
        .thresh_i     (thresh_w),
        .bit_o        (bit_o),
        .valid_o      (bit_valid_o),
        .primed_o     (primed_w)
    );
endmodule

// File: rtl/mbr_checker.sv
module mbr_checker #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             edge_i,
    input logic             primed_i,
    input logic             level_prev_i,
    input logic             polarity_i,
    input logic [CNT_W-1:0] interval_i,
    input logic [CNT_W-1:0] thresh_i,
    input logic             bit_o,
    input logic             valid_o
);
    assert_reset_quiet_R10: assert property (@(posedge clk)
        !rst_n |=> !valid_o);

    assert_first_edge_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i && !primed_i |=> !valid_o);

    assert_long_emits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i && primed_i && (interval_i > thresh_i) |=> valid_o);

    assert_bit_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i && primed_i |=> (!valid_o || bit_o == $past(level_prev_i ^ polarity_i)));

    assert_strobe_after_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(edge_i));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (interval_i == '1) && !edge_i |=> (interval_i == '1));
endmodule

bind manchester_bit_recover mbr_checker #(.CNT_W(CNT_W)) u_mbr_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .edge_i       (edge_w),
    .primed_i     (primed_w),
    .level_prev_i (level_prev_w),
    .polarity_i   (polarity_i),
    .interval_i   (interval_w),
    .thresh_i     (thresh_w),
    .bit_o        (bit_o),
    .valid_o      (bit_valid_o)
);

// File: tb/manchester_bit_recover_bench.sv
module manchester_bit_recover_bench;
    localparam int SPC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic       pol = 1'b1;
    logic       bit_o;
    logic       valid_o;

    always #4 clk = ~clk;   // 125 MHz

    manchester_bit_recover u_manchester_bit_recover (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_i      (line),
        .rate_sel_i  (rate_sel),
        .polarity_i  (pol),
        .bit_o       (bit_o),
        .bit_valid_o (valid_o)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int exp_bit[$];
    int exp_cyc[$];

    // requirement model state
    bit m_primed, m_prev_long, m_prev_emit;
    int m_last_c;
    int thr;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // called when the bench changes the line at cycle c
    task automatic model_edge(input int c, input bit old_level);
        int d;
        bit lng, emit;
        if (!m_primed) begin
            m_primed = 1'b1;          // R7: first transition only starts timing
            m_prev_long = 1'b0;
            m_prev_emit = 1'b0;
        end else begin
            d    = c - m_last_c;
            lng  = (d > thr);          // R2
            emit = lng || m_prev_long || !m_prev_emit;  // R3 R4 R5
            if (emit) begin
                exp_bit.push_back(int'(old_level ^ pol));  // R6
                exp_cyc.push_back(c + 3);                   // R9
            end
            m_prev_long = lng;
            m_prev_emit = emit;
        end
        m_last_c = c;
    endtask

    task automatic run(input bit level, input int dur);
        @(negedge clk);
        if (level != line) begin
            model_edge(cyc, line);
            line = level;
        end
        repeat (dur - 1) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (exp_bit.size() == 0) begin
                chk(1'b0, "R3/R4/R5 unexpected strobe", 1, 0);
            end else begin
                int eb, ec;
                eb = exp_bit.pop_front();
                ec = exp_cyc.pop_front();
                chk(int'(bit_o) == eb, "R6 bit value", int'(bit_o), eb);
                chk(cyc == ec, "R9 strobe cycle", cyc, ec);
            end
        end
    end

    task automatic start_seg(input logic [1:0] rs, input int rate, input bit p);
        rst_n = 1'b0;
        line  = 1'b0;
        rate_sel = rs;
        pol   = p;
        repeat (4) @(negedge clk);
        chk(valid_o == 1'b0, "R10 strobe low in reset", int'(valid_o), 0);
        chk(bit_o == 1'b0, "R10 bit low in reset", int'(bit_o), 0);
        exp_bit.delete();
        exp_cyc.delete();
        m_primed = 1'b0;
        thr = (SPC * rate) - (SPC * rate) / 4;  // R1 R2
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic end_seg(input int hold);
        repeat (hold) @(negedge clk);
        chk(exp_bit.size() == 0, "R3/R4/R5 missing strobes", exp_bit.size(), 0);
    endtask

    task automatic random_seg(input logic [1:0] rs, input int rate, input bit p, input int nbits);
        int period, half;
        bit lv[$];
        start_seg(rs, rate, p);
        period = SPC * rate;
        half   = period / 2;
        run(1'b1, period);  // preamble: its start is the initialising transition
        for (int i = 0; i < nbits; i++) begin
            bit b;
            b = 1'($urandom % 2);
            lv.push_back(b);
            lv.push_back(!b);
        end
        begin
            int k;
            k = 0;
            while (k < lv.size()) begin
                int n, dur, j;
                n = 1;
                while (k + n < lv.size() && lv[k + n] == lv[k]) n++;
                j = int'($urandom_range(period / 8, 0)) - period / 16;
                dur = n * half + j;
                run(lv[k], dur);
                k += n;
            end
            run(!lv[lv.size() - 1], 3 * period);
        end
        end_seg(10);
    endtask

    initial begin
        void'($urandom(32'd7));
        // random frames across rates (R1) and both polarities (R6)
        random_seg(2'd0, 64, 1'b1, 24);
        random_seg(2'd1, 32, 1'b0, 24);
        random_seg(2'd2, 16, 1'b1, 24);
        random_seg(2'd3, 64, 1'b0, 24);
        random_seg(2'd2, 16, 1'b0, 24);

        // directed: R7 first edge, R8 saturation past counter range, R5 short runs
        start_seg(2'd0, 64, 1'b1);
        run(1'b1, 50);        // first transition: no bit
        run(1'b0, 2148);      // long idle beyond counter range
        run(1'b1, 60);        // ends the idle: long, R8
        run(1'b0, 60);        // short after long, R4
        run(1'b1, 60);        // short after emitting short: silent, R5
        run(1'b0, 60);        // short after silent short: emits, R5
        run(1'b1, 100);
        run(1'b0, 250);       // long, R3
        run(1'b1, 400);
        end_seg(10);

        // directed: R2 boundary at rate 16 (threshold 48)
        start_seg(2'd2, 16, 1'b1);
        run(1'b1, 30);
        run(1'b0, 48);        // equal to threshold: short
        run(1'b1, 49);        // just above: long
        run(1'b0, 48);        // short after long
        run(1'b1, 48);        // short after emitting short: silent
        run(1'b0, 200);
        end_seg(10);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule